// File: doc/BRIEF.md
# Atomic Reservation Tracker

This block keeps the single reservation that a processor core needs for atomic read-modify-write sequences built from a load-and-reserve and a store-conditional. A load-and-reserve captures the 32-byte-aligned granule that holds its address and arms a valid flag. A later store-conditional may go to the bus only while that flag is still armed and its own address falls in the same granule. The tracker returns the outcome to the core as a one-cycle result.

Other bus masters' writes and kills are fed in on a set of snoop ports. A hit on the reserved granule disarms the reservation. The armed flag leaves the block as a registered status pin, timed by the bus clock. The tracker does not track reservations for other masters: each of them keeps its own.

Requests from the core arrive on a valid/ready stream. The tracker never applies back-pressure: `req_ready` is high in every cycle after reset, and each request is taken in the cycle in which `req_valid` is high. The result port has no ready. The core must be able to take one result per accepted store-conditional.

Top module: `resv_tracker`

## Requirements
- R1: After reset, `rsrv` is 0 and `rsp_valid` is 0.
- R2: An accepted load-and-reserve (`req_op`=0) drives `rsrv` to 1 one clock later, unless R9 applies.
- R3: An accepted store-conditional (`req_op`=1) gives `rsp_pass`=1 when `rsrv` is 1 and `req_addr[31:5]` equals the reserved granule. Address bits [4:0] take no part in the comparison.
- R4: An accepted store-conditional gives `rsp_pass`=0 when `rsrv` is 0, or when `req_addr[31:5]` differs from the reserved granule.
- R5: Any accepted store-conditional, passing or failing, drives `rsrv` to 0 one clock later.
- R6: A snoop with `snp_valid[i]`=1 whose `snp_addr[i][31:5]` matches the reserved granule clears `rsrv` one clock later. A snoop to any other granule leaves `rsrv` unchanged.
- R7: A new load-and-reserve replaces the earlier granule. A store-conditional to the old granule then fails.
- R8: A snoop that hits the reserved granule in the same cycle as a store-conditional makes that store-conditional fail.
- R9: A snoop that hits the incoming granule in the same cycle as a load-and-reserve leaves `rsrv` at 0.
- R10: `req_ready` is 1 in every cycle after reset. `rsp_valid` is high for exactly one cycle, the cycle after each accepted store-conditional, and never follows a load-and-reserve.
- R11: `rsrv` is registered. It rises only in the cycle after an accepted load-and-reserve, and its value is the current armed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted (always 1 after reset) |
| req_op | input | 1 | 0 = load-and-reserve, 1 = store-conditional |
| req_addr | input | 32 | Byte address of the request |
| snp_valid | input | 2 | One valid bit per snoop port (write or kill by another master) |
| snp_addr | input | 2x32 | Byte address per snoop port |
| rsrv | output | 1 | Reservation status, registered |
| rsp_valid | output | 1 | One-cycle store-conditional result strobe |
| rsp_pass | output | 1 | Store-conditional outcome, qualified by rsp_valid |

## Verification
A request and a snoop can land in the same cycle, and the two collisions of interest are a store-conditional racing a snoop to the reserved granule and a load-and-reserve racing a snoop to the granule it is arming. Directed steps drive both kinds of collision, with the snoop on either port and with different low address bits. The random phase draws addresses from four granules so that such overlaps happen often. A bench model judges each cycle by applying one rule: a same-cycle snoop hit always wins, so the store-conditional fails or the reservation stays disarmed.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic {
    OP_LOAD_RSV   = 1'b0,
    OP_STORE_COND = 1'b1
  } resv_op_e;
endpackage

// File: rtl/resv_tag_eq.sv
// Granule comparison: equal when the bits above the granule offset match.
module resv_tag_eq #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 5,
  localparam int TAG_W    = ADDR_W - GRAN_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  tag,
  output logic              eq
);
  logic unused_offset;
  assign unused_offset = ^addr[GRAN_BITS-1:0];
  assign eq = (addr[ADDR_W-1:GRAN_BITS] == tag);
endmodule

// File: rtl/resv_snoop_match.sv
// Any valid snoop port that falls inside the given granule.
module resv_snoop_match #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 5,
  parameter int N_SNP     = 2,
  localparam int TAG_W    = ADDR_W - GRAN_BITS
) (
  input  logic [N_SNP-1:0]             snp_valid,
  input  logic [N_SNP-1:0][ADDR_W-1:0] snp_addr,
  input  logic [TAG_W-1:0]             tag,
  output logic                         hit
);
  logic [N_SNP-1:0] port_eq;
  for (genvar i = 0; i < N_SNP; i++) begin : g_port
    resv_tag_eq #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_eq (
      .addr(snp_addr[i]),
      .tag (tag),
      .eq  (port_eq[i])
    );
  end
  assign hit = |(port_eq & snp_valid);
endmodule

// File: rtl/resv_state.sv
// Reservation register: armed flag plus granule tag.
module resv_state #(
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_arm,
  input  logic [TAG_W-1:0] load_tag,
  input  logic             clear,
  output logic             armed,
  output logic [TAG_W-1:0] tag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      tag   <= '0;
    end else if (load) begin
      armed <= load_arm;
      tag   <= load_tag;
    end else if (clear) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/resv_result.sv
// Registered store-conditional outcome strobe.
module resv_result (
  input  logic clk,
  input  logic rst_n,
  input  logic sc_fire,
  input  logic sc_ok,
  output logic rsp_valid,
  output logic rsp_pass
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pass  <= 1'b0;
    end else begin
      rsp_valid <= sc_fire;
      rsp_pass  <= sc_fire & sc_ok;
    end
  end
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 5,
  parameter int N_SNP     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_op,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [N_SNP-1:0]             snp_valid,
  input  logic [N_SNP-1:0][ADDR_W-1:0] snp_addr,
  output logic                         rsrv,
  output logic                         rsp_valid,
  output logic                         rsp_pass
);
  import resv_pkg::*;
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic             ready_q;
  logic             armed;
  logic [TAG_W-1:0] cur_tag;
  logic [TAG_W-1:0] req_tag;
  logic             req_in_granule;
  logic             snp_hit_cur;
  logic             snp_hit_req;
  logic             take;
  logic             is_lr;
  logic             is_sc;
  resv_op_e         op;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign req_ready = ready_q;

  assign op      = resv_op_e'(req_op);
  assign take    = req_valid & req_ready;
  assign is_lr   = take & (op == OP_LOAD_RSV);
  assign is_sc   = take & (op == OP_STORE_COND);
  assign req_tag = req_addr[ADDR_W-1:GRAN_BITS];

  resv_tag_eq #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_req_eq (
    .addr(req_addr),
    .tag (cur_tag),
    .eq  (req_in_granule)
  );

  // Snoops against the stored granule.
  resv_snoop_match #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .N_SNP(N_SNP)) u_snp_cur (
    .snp_valid(snp_valid),
    .snp_addr (snp_addr),
    .tag      (cur_tag),
    .hit      (snp_hit_cur)
  );

  // Snoops against the granule a load-and-reserve is arming.
  resv_snoop_match #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .N_SNP(N_SNP)) u_snp_req (
    .snp_valid(snp_valid),
    .snp_addr (snp_addr),
    .tag      (req_tag),
    .hit      (snp_hit_req)
  );

  resv_state #(.TAG_W(TAG_W)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (is_lr),
    .load_arm(~snp_hit_req),
    .load_tag(req_tag),
    .clear   (is_sc | snp_hit_cur),
    .armed   (armed),
    .tag     (cur_tag)
  );

  resv_result u_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .sc_fire  (is_sc),
    .sc_ok    (armed & req_in_granule & ~snp_hit_cur),
    .rsp_valid(rsp_valid),
    .rsp_pass (rsp_pass)
  );

  assign rsrv = armed;
endmodule

// File: rtl/resv_tracker_chk.sv
module resv_tracker_chk #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 5,
  parameter int N_SNP     = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic                         req_op,
  input logic [ADDR_W-1:0]            req_addr,
  input logic [N_SNP-1:0]             snp_valid,
  input logic [N_SNP-1:0][ADDR_W-1:0] snp_addr,
  input logic                         rsrv,
  input logic                         rsp_valid,
  input logic                         rsp_pass
);
  logic acc_sc, acc_lr, snp_on_req;
  assign acc_sc = req_valid & req_ready & req_op;
  assign acc_lr = req_valid & req_ready & ~req_op;

  always_comb begin
    snp_on_req = 1'b0;
    for (int i = 0; i < N_SNP; i++)
      if (snp_valid[i] && snp_addr[i][ADDR_W-1:GRAN_BITS] == req_addr[ADDR_W-1:GRAN_BITS])
        snp_on_req = 1'b1;
  end

  a_r2_lr_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_lr && !snp_on_req) |=> rsrv);
  a_r4_no_rsv_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sc && !rsrv) |=> (rsp_valid && !rsp_pass));
  a_r5_sc_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sc |=> !rsrv);
  a_r8_snoop_beats_sc: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sc && snp_on_req) |=> !rsp_pass);
  a_r9_snoop_beats_lr: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_lr && snp_on_req) |=> !rsrv);
  a_r10_strobe_follows_sc: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_sc |=> !rsp_valid);
  a_r10_pass_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pass |-> rsp_valid);
  a_r11_rise_after_lr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsrv) |-> $past(acc_lr));
  a_r3_pass_needs_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_pass) |-> $past(rsrv));
endmodule

bind resv_tracker resv_tracker_chk #(
  .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .N_SNP(N_SNP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_addr(req_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
  .rsrv(rsrv), .rsp_valid(rsp_valid), .rsp_pass(rsp_pass)
);

// File: tb/tb_resv_tracker.sv
module tb_resv_tracker;
  localparam int AW = 32;
  localparam int GB = 5;
  localparam int NS = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic               req_op = 1'b0;
  logic [AW-1:0]      req_addr = '0;
  logic [NS-1:0]      snp_valid = '0;
  logic [NS-1:0][AW-1:0] snp_addr = '0;
  logic               rsrv, rsp_valid, rsp_pass;

  int n_chk = 0;
  int n_bad = 0;
  bit m_vld = 0;
  logic [AW-GB-1:0] m_tag = '0;

  always #5 clk = ~clk;

  resv_tracker #(.ADDR_W(AW), .GRAN_BITS(GB), .N_SNP(NS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .rsrv(rsrv), .rsp_valid(rsp_valid), .rsp_pass(rsp_pass)
  );

  function automatic logic [AW-GB-1:0] gran(input logic [AW-1:0] a);
    return a[AW-1:GB];
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model the rules, check at next negedge.
  task automatic step(input string req, input bit v, input bit op, input logic [AW-1:0] a,
                      input logic [NS-1:0] sv, input logic [AW-1:0] s0, input logic [AW-1:0] s1);
    bit hit_old, hit_new, e_rv, e_ps, e_vld;
    logic [AW-GB-1:0] e_tag;
    req_valid = v; req_op = op; req_addr = a;
    snp_valid = sv; snp_addr[0] = s0; snp_addr[1] = s1;
    check("R10", "req_ready", req_ready, 1'b1);
    hit_old = (sv[0] && gran(s0) == m_tag) || (sv[1] && gran(s1) == m_tag);
    hit_new = (sv[0] && gran(s0) == gran(a)) || (sv[1] && gran(s1) == gran(a));
    e_rv = v && op;
    e_ps = e_rv && m_vld && gran(a) == m_tag && !hit_old;
    e_vld = m_vld; e_tag = m_tag;
    if (v && !op) begin e_vld = !hit_new; e_tag = gran(a); end
    else if (v && op) e_vld = 0;
    else if (hit_old) e_vld = 0;
    @(posedge clk);
    @(negedge clk);
    m_vld = e_vld; m_tag = e_tag;
    check(req, "rsrv", rsrv, e_vld);
    check(req, "rsp_valid", rsp_valid, e_rv);
    if (e_rv) check(req, "rsp_pass", rsp_pass, e_ps);
    req_valid = 0; snp_valid = '0;
  endtask

  localparam logic [AW-1:0] GA = 32'h0000_1000;
  localparam logic [AW-1:0] GB_ = 32'h0000_1020;
  localparam logic [AW-1:0] GC = 32'h8000_0040;

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "rsrv after reset", rsrv, 1'b0);
    check("R1", "rsp_valid after reset", rsp_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: store-conditional with nothing reserved.
    step("R4", 1, 1, GA, 2'b00, 0, 0);
    // R2 then R3 with different low bits.
    step("R2", 1, 0, GA + 4, 2'b00, 0, 0);
    step("R11", 0, 0, 0, 2'b00, 0, 0);
    step("R3", 1, 1, GA + 28, 2'b00, 0, 0);
    // R5: reservation now gone, repeat fails.
    step("R5", 1, 1, GA, 2'b00, 0, 0);
    // R4: mismatching granule fails, and R5 clears anyway.
    step("R2", 1, 0, GA, 2'b00, 0, 0);
    step("R4", 1, 1, GB_, 2'b00, 0, 0);
    // R6: snoop elsewhere harmless, snoop on granule clears.
    step("R2", 1, 0, GC, 2'b00, 0, 0);
    step("R6", 0, 0, 0, 2'b01, GA, 0);
    step("R6", 0, 0, 0, 2'b10, 0, GC + 17);
    step("R4", 1, 1, GC, 2'b00, 0, 0);
    // R7: new load-and-reserve replaces old granule.
    step("R2", 1, 0, GA, 2'b00, 0, 0);
    step("R7", 1, 0, GB_, 2'b00, 0, 0);
    step("R7", 1, 1, GA, 2'b00, 0, 0);
    // R8: snoop in same cycle as passing store-conditional.
    step("R2", 1, 0, GB_, 2'b00, 0, 0);
    step("R8", 1, 1, GB_, 2'b10, 0, GB_ + 3);
    // R9: snoop hits the granule being armed.
    step("R9", 1, 0, GC, 2'b01, GC + 9, 0);
    step("R9", 1, 1, GC, 2'b00, 0, 0);
    // Random phase over four granules.
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a, s0, s1;
      bit v, op;
      logic [NS-1:0] sv;
      a  = {25'd0, 2'($urandom_range(0, 3)), 5'($urandom)};
      s0 = {25'd0, 2'($urandom_range(0, 3)), 5'($urandom)};
      s1 = {25'd0, 2'($urandom_range(0, 3)), 5'($urandom)};
      v  = ($urandom_range(0, 3) != 0);
      op = $urandom_range(0, 1);
      sv = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
      step(!v ? "R6" : (op ? "R3" : "R2"), v, op, a, sv, s0, s1);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule